// File: doc/BRIEF.md
# Write Status Read Multiplexer

This block chooses the byte that a memory device returns on a host read. While the device is idle it passes the addressed array data through. During the byte-load window, and while an internal programming cycle runs, it returns a status byte instead. The status byte lets the host poll for completion without a separate status register. It tracks the bus strobes in the chip's clock domain, and it drives the data bus only for a genuine read strobe.

The status byte has fixed bit positions:
- bit 7 is the complement of bit 7 of the most recently loaded byte (polling bit);
- bit 6 flips once per host read (toggle bit);
- bit 5 reports the page-load timer;
- bit 1 reports a page-write abort;
- bit 0 reports whether software write protection is on;
- bits 4 to 2 are driven low.

The toggle bit returns 0 on the first read after the status period begins. The block holds no array storage and performs no write sequencing. Those functions are neighbours that supply the busy, window, timer, abort and protection inputs. Every output is registered, so a change at the strobes or data inputs is seen on the outputs one clock later.

Top module: `wsr_read_mux`

## Requirements
- R1: `dq_oe` is 1 in a cycle exactly when, at the previous clock edge, `ce_n`=0, `oe_n`=0 and `we_n`=1. Whenever `dq_oe` is 0, `dq_out` is 0 (bus released).
- R2: A read in which neither `prog_busy` nor `load_active` was 1 at that clock edge returns `array_rdata` unchanged, one clock later.
- R3: In a status read (`prog_busy` or `load_active` high), `dq_out[7]` equals the inverse of `last_byte[7]`.
- R4: In status mode, `dq_out[6]` is 0 on the first read after status mode is entered. It then inverts on each later read. A read begins when `oe_n` falls while `ce_n`=0 and `we_n`=1.
- R5: In a status read, `dq_out[5]` = `timer_expired`, `dq_out[1]` = `page_abort` and `dq_out[0]` = `protect_on` (1 = protected).
- R6: In a status read, `dq_out[4:2]` is 000.
- R7: While only `load_active` is high, the abort flag is reported in bit 1 whether `protect_on` is 0 or 1.
- R8: Once `prog_busy` falls, reads again return all eight bits of `array_rdata`, with no polling or toggle substitution.
- R9: Out of reset, `dq_oe` and `dq_out` are both 0.
- R10: `oe_n` transitions with `ce_n`=1 do not advance the toggle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| prog_busy | input | 1 | Internal programming cycle running |
| load_active | input | 1 | Byte-load window open |
| last_byte | input | 8 | Most recently loaded data byte |
| timer_expired | input | 1 | Page-load timer has run out |
| page_abort | input | 1 | Page-write abort flag |
| protect_on | input | 1 | Software write protection enabled |
| array_rdata | input | 8 | Addressed array contents |
| dq_out | output | 8 | Registered read byte |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions assume that the strobes, mode flags and data inputs are synchronous to `clk` and settle between edges. They also assume that the status inputs describe the same cycle as the strobes that sample them. The stimulus meets both assumptions by changing every input only on the falling clock edge. Each strobe step is held for at least one full clock, so every falling edge of `oe_n` is seen as a distinct read. Status periods are always separated by at least one idle clock, so the entry that resets the toggle bit is visible to the block.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int BYTE_W = 8;
  localparam int RSV_W  = 3;

  // Field order fixes the bit position each reader decodes.
  typedef struct packed {
    logic             poll;   // bit 7
    logic             tog;    // bit 6
    logic             tmr;    // bit 5
    logic [RSV_W-1:0] rsv;    // bits 4..2
    logic             abort;  // bit 1
    logic             prot;   // bit 0
  } stat_byte_t;
endpackage

// File: rtl/wsr_bus_decode.sv
module wsr_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic read_cond,
  output logic read_start
);
  logic oe_prev_q;
  logic oe_prev_d;

  always_comb begin
    read_cond  = ~ce_n & ~oe_n & we_n;
    read_start = read_cond & oe_prev_q;
    oe_prev_d  = oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_prev_q <= 1'b1;
    else        oe_prev_q <= oe_prev_d;
  end
endmodule

// File: rtl/wsr_toggle_gen.sv
module wsr_toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic win_open,
  input  logic read_start,
  output logic tog_now
);
  logic win_q, win_d;
  logic held_q, held_d;
  logic next_q, next_d;
  logic next_eff;

  always_comb begin
    win_d    = win_open;
    next_eff = (win_open & ~win_q) ? 1'b0 : next_q;
    if (read_start) begin
      held_d = next_eff;
      next_d = ~next_eff;
    end else begin
      held_d = held_q;
      next_d = next_eff;
    end
    tog_now = held_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      held_q <= 1'b0;
      next_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      held_q <= held_d;
      next_q <= next_d;
    end
  end
endmodule

// File: rtl/wsr_status_fmt.sv
module wsr_status_fmt
  import wsr_pkg::*;
(
  input  logic       last_msb,
  input  logic       tog,
  input  logic       tmr,
  input  logic       abort,
  input  logic       prot,
  output stat_byte_t stat
);
  always_comb begin
    stat.poll  = ~last_msb;
    stat.tog   = tog;
    stat.tmr   = tmr;
    stat.rsv   = '0;
    stat.abort = abort;
    stat.prot  = prot;
  end
endmodule

// File: rtl/wsr_read_mux.sv
module wsr_read_mux
  import wsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              prog_busy,
  input  logic              load_active,
  input  logic [BYTE_W-1:0] last_byte,
  input  logic              timer_expired,
  input  logic              page_abort,
  input  logic              protect_on,
  input  logic [BYTE_W-1:0] array_rdata,
  output logic [BYTE_W-1:0] dq_out,
  output logic              dq_oe
);
  logic              read_cond;
  logic              read_start;
  logic              win_open;
  logic              tog_now;
  stat_byte_t        stat;
  logic              drive_q, drive_d;
  logic [BYTE_W-1:0] data_q, data_d;

  assign win_open = prog_busy | load_active;

  wsr_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .read_cond(read_cond), .read_start(read_start)
  );

  wsr_toggle_gen u_tog (
    .clk(clk), .rst_n(rst_n), .win_open(win_open),
    .read_start(read_start), .tog_now(tog_now)
  );

  wsr_status_fmt u_fmt (
    .last_msb(last_byte[BYTE_W-1]), .tog(tog_now), .tmr(timer_expired),
    .abort(page_abort), .prot(protect_on), .stat(stat)
  );

  always_comb begin
    drive_d = read_cond;
    if (!read_cond)    data_d = '0;
    else if (win_open) data_d = stat;
    else               data_d = array_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      data_q  <= '0;
    end else begin
      drive_q <= drive_d;
      data_q  <= data_d;
    end
  end

  assign dq_out = data_q;
  assign dq_oe  = drive_q;
endmodule

// File: rtl/wsr_read_mux_chk.sv
module wsr_read_mux_chk
  import wsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              prog_busy,
  input logic              load_active,
  input logic [BYTE_W-1:0] last_byte,
  input logic              timer_expired,
  input logic              page_abort,
  input logic              protect_on,
  input logic [BYTE_W-1:0] array_rdata,
  input logic [BYTE_W-1:0] dq_out,
  input logic              dq_oe
);
  a_r1_drive_cond: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_n && !oe_n && we_n));

  a_r1_released: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  a_r2_array: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !$past(prog_busy || load_active)) |-> (dq_out == $past(array_rdata)));

  a_r3_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(prog_busy || load_active)) |-> (dq_out[7] == !$past(last_byte[7])));

  a_r4_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(prog_busy || load_active) && !$past(prog_busy || load_active, 2)
     && $past(oe_n, 2)) |-> (dq_out[6] == 1'b0));

  a_r5_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(prog_busy || load_active)) |->
      (dq_out[5] == $past(timer_expired) && dq_out[1] == $past(page_abort)
       && dq_out[0] == $past(protect_on)));

  a_r6_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(prog_busy || load_active)) |-> (dq_out[4:2] == 3'b000));
endmodule

bind wsr_read_mux wsr_read_mux_chk u_chk (.*);

// File: tb/wsr_read_mux_tb.sv
module wsr_read_mux_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       ce_n, oe_n, we_n, busy, ld, tmr, abt, prt;
  logic [7:0] lb, arr;
  logic [7:0] dq_out;
  logic       dq_oe;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 0;

  wsr_read_mux u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .prog_busy(busy), .load_active(ld), .last_byte(lb),
    .timer_expired(tmr), .page_abort(abt), .protect_on(prt),
    .array_rdata(arr), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // Behavioural reference, advanced on each rising edge.
  bit       m_oeprev, m_statprev, m_held, m_nxt, m_eoe, m_estat;
  bit [7:0] m_edata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oeprev = 1; m_statprev = 0; m_held = 0; m_nxt = 0;
      m_eoe = 0; m_estat = 0; m_edata = 0;
    end else begin
      bit rd, st, ne;
      rd = !ce_n && !oe_n && we_n;
      st = busy || ld;
      ne = (st && !m_statprev) ? 1'b0 : m_nxt;
      if (rd && m_oeprev) begin m_held = ne; m_nxt = !ne; end
      else m_nxt = ne;
      m_oeprev = oe_n;
      m_statprev = st;
      m_eoe = rd;
      m_estat = st;
      if (!rd) m_edata = 0;
      else if (st) m_edata = {!lb[7], m_held, tmr, 3'b000, abt, prt};
      else m_edata = arr;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1", {7'd0, dq_oe}, {7'd0, m_eoe});
    if (!m_eoe) chk("R1", dq_out, 8'h00);
    else if (m_estat) begin
      chk("R3", {7'd0, dq_out[7]}, {7'd0, m_edata[7]});
      chk("R4", {7'd0, dq_out[6]}, {7'd0, m_edata[6]});
      chk("R5", {5'd0, dq_out[5], dq_out[1:0]}, {5'd0, m_edata[5], m_edata[1:0]});
      chk("R6", {5'd0, dq_out[4:2]}, 8'h00);
    end else chk("R2", dq_out, m_edata);
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic do_read(output logic [7:0] v, output logic oe);
    ce_n = 0; we_n = 1; oe_n = 0;
    cyc();
    v = dq_out; oe = dq_oe;
    oe_n = 1; ce_n = 1;
    cyc();
  endtask

  task automatic rd_expect(input string req, input logic [7:0] exp);
    logic [7:0] v;
    logic       o;
    do_read(v, o);
    chk(req, {7'd0, o}, 8'h01);
    chk(req, v, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; busy = 0; ld = 0;
    tmr = 0; abt = 0; prt = 0; lb = 8'h00; arr = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9", {7'd0, dq_oe}, 8'h00);
    chk("R9", dq_out, 8'h00);
    rst_n = 1;
    cyc();
    chk("R9", {7'd0, dq_oe}, 8'h00);

    // Array reads with no status period.
    arr = 8'hA5; rd_expect("R2", 8'hA5);
    arr = 8'h3C; rd_expect("R2", 8'h3C);

    // Strobe combinations that must not drive.
    ce_n = 1; oe_n = 0; we_n = 1; cyc(); cyc();
    chk("R1", {7'd0, dq_oe}, 8'h00);
    ce_n = 0; oe_n = 0; we_n = 0; cyc(); cyc();
    chk("R1", {7'd0, dq_oe}, 8'h00);
    chk("R1", dq_out, 8'h00);
    ce_n = 1; oe_n = 1; we_n = 1; cyc();

    // First programming period.
    busy = 1; lb = 8'h80; tmr = 1; abt = 0; prt = 1;
    rd_expect("R4", 8'h21);
    rd_expect("R4", 8'h61);
    rd_expect("R3", 8'h21);
    ce_n = 1; we_n = 1;
    for (int i = 0; i < 3; i++) begin oe_n = 0; cyc(); oe_n = 1; cyc(); end
    rd_expect("R10", 8'h61);
    lb = 8'h00; rd_expect("R3", 8'hA1);
    busy = 0; arr = 8'hC5; cyc();
    rd_expect("R8", 8'hC5);
    arr = 8'h40; rd_expect("R8", 8'h40);

    // Second programming period: toggle restarts.
    busy = 1; lb = 8'h7F; tmr = 0; abt = 0; prt = 0;
    rd_expect("R4", 8'h80);
    busy = 0; cyc(); cyc();

    // Byte-load window: abort visible in both protection states.
    ld = 1; abt = 1; prt = 0; lb = 8'h00; tmr = 0;
    rd_expect("R7", 8'h82);
    prt = 1; rd_expect("R7", 8'hC3);
    tmr = 1; rd_expect("R5", 8'hA3);
    ld = 0; abt = 0; cyc();
    arr = 8'h5A; rd_expect("R2", 8'h5A);

    repeat (2) cyc();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule